// File: doc/BRIEF.md
# Cascaded Two-Controller Interrupt Vectoring

This block pairs two eight-line interrupt resolvers, one acting as master and one as slave, and turns a processor acknowledge strobe into an 8-bit interrupt vector. Each resolver latches requests, applies a mask, and picks the lowest-numbered unmasked request. A request is only offered when no line of equal or higher priority is already in service. Whenever the slave has something to offer, the request is carried to the master as a one-cycle pulse on master line 2. The processor interrupt output follows the master's pending state.

A single-cycle `inta` strobe takes the master's pending line and marks it in service. If that line is the cascade line, the slave's pending line is taken as well. The vector comes from the chosen controller's programmed base plus the line number. When a controller has nothing pending at that moment, the vector falls back to that controller's line 7. Mask, trigger-mode and vector-base registers are loaded through simple write strobes. An end-of-interrupt strobe retires the highest-priority in-service line of the selected controller.

Top module: `pic_cascade_top`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `intr_out` and `vec_valid` are 0 and `vec_out` is 0x00.
- R2: A rising edge on an unmasked, edge-mode request line sets that line's latched request at the next clock. On the master, `intr_out` goes high in that same cycle, and the request stays latched until it is acknowledged.
- R3: Among pending unmasked lines, the lowest line number wins. A line is not offered while a line of the same or a lower number is in service.
- R4: Writing 1 to a mask bit (`mask_we`; `reg_sel` 0 selects the master and 1 the slave; bit n of `reg_data` is line n) stops that line from being offered, while its latched request is kept. Clearing the bit offers it again.
- R5: A pending slave line sets master line 2 one clock later, so `intr_out` rises two clocks after a slave request edge. The `master_irq[2]` input has no effect.
- R6: A vector base write keeps only bits 7:3. After an `inta` strobe, `vec_out` holds base + line, and `vec_valid` is high for exactly one cycle in the next cycle.
- R7: When the master's pending line is 2, both the master and the slave take their pending lines into service, and the vector uses the slave base plus the slave line.
- R8: If the master has no pending line at `inta`, the vector is master base + 7 and nothing is taken into service.
- R9: If the master offers line 2 but the slave has no pending line at `inta`, the vector is slave base + 7.
- R10: A trigger-mode bit of 1 makes the line level-sensitive: its request follows the input and is not cleared by acknowledge. Master lines 0, 1 and 2 and slave lines 0 and 5 always stay edge-triggered.
- R11: An `eoi` strobe clears only the lowest-numbered in-service line of the controller chosen by `eoi_sel` (0 master, 1 slave).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_irq | input | 8 | Master request lines (bit 2 unused) |
| slave_irq | input | 8 | Slave request lines |
| mask_we | input | 1 | Load mask register of selected controller |
| trig_we | input | 1 | Load trigger-mode register of selected controller |
| base_we | input | 1 | Load vector base of selected controller |
| reg_sel | input | 1 | Register target: 0 master, 1 slave |
| reg_data | input | 8 | Register write data |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_sel | input | 1 | End-of-interrupt target: 0 master, 1 slave |
| inta | input | 1 | Acknowledge strobe |
| intr_out | output | 1 | Processor interrupt request |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | One-cycle strobe marking a new vector |

## Verification
Master-only requests on several lines tell apart correct priority order, in-service blocking and mask handling, while a slave request distinguishes cascaded vectoring from a direct master vector. Acknowledges with nothing pending, and with a slave request masked after it reached the master, separate the two spurious fallbacks. Level-mode requests that stay high or drop before acknowledge show the difference between the two trigger modes and confirm the forced-edge lines. A behavioural model in the bench tracks latched requests, service state and vectors on every clock, alongside directed checks with fixed expected vectors.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic { SEL_MASTER = 1'b0, SEL_SLAVE = 1'b1 } ctl_sel_e;

  function automatic logic [7:0] vec_of(input logic [7:0] base, input logic [2:0] line);
    return base + {5'd0, line};
  endfunction
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [LW-1:0] idx
);
  // lowest set index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int           N         = 8,
  parameter int           VW        = 8,
  parameter logic [N-1:0] TRIG_MASK = '1,
  parameter int           LW        = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_level,
  input  logic [N-1:0]  req_pulse,
  input  logic          mask_we,
  input  logic          trig_we,
  input  logic          base_we,
  input  logic [VW-1:0] wdata,
  input  logic          eoi,
  input  logic          ack,
  output logic          pend_valid,
  output logic [LW-1:0] pend_line,
  output logic [VW-1:0] base_q
);
  logic [N-1:0] irr, isr, imr, trig, last;
  logic [N-1:0] ack_hot, eoi_hot, rise, irr_next;
  logic         req_found, svc_found;
  logic [LW-1:0] req_idx, svc_idx;

  pic_prio_enc #(.N(N), .LW(LW)) u_req_enc (
    .bits(irr & ~imr), .found(req_found), .idx(req_idx));

  pic_prio_enc #(.N(N), .LW(LW)) u_svc_enc (
    .bits(isr), .found(svc_found), .idx(svc_idx));

  assign pend_valid = req_found && (!svc_found || (req_idx < svc_idx));
  assign pend_line  = req_idx;

  assign ack_hot = (ack && pend_valid) ? (N'(1) << pend_line) : '0;
  assign eoi_hot = (eoi && svc_found) ? (N'(1) << svc_idx) : '0;
  assign rise    = req_level & ~last;

  // per-line request latch: level lines follow input, edge lines hold until acked
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      always_comb begin
        if (trig[g]) irr_next[g] = req_level[g] | req_pulse[g];
        else         irr_next[g] = (irr[g] & ~ack_hot[g]) | rise[g] | req_pulse[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irr    <= '0;
      isr    <= '0;
      imr    <= '0;
      trig   <= '0;
      last   <= '0;
      base_q <= '0;
    end else begin
      irr  <= irr_next;
      isr  <= (isr | ack_hot) & ~eoi_hot;
      last <= req_level;
      if (mask_we) imr  <= wdata[N-1:0];
      if (trig_we) trig <= wdata[N-1:0] & TRIG_MASK;
      if (base_we) base_q <= {wdata[VW-1:LW], {LW{1'b0}}};
    end
  end
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top #(
  parameter int           N           = 8,
  parameter int           VW          = 8,
  parameter int           CASC_LINE   = 2,
  parameter int           SPUR_LINE   = 7,
  parameter logic [N-1:0] M_TRIG_MASK = 8'hF8,
  parameter logic [N-1:0] S_TRIG_MASK = 8'hDE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  master_irq,
  input  logic [N-1:0]  slave_irq,
  input  logic          mask_we,
  input  logic          trig_we,
  input  logic          base_we,
  input  logic          reg_sel,
  input  logic [VW-1:0] reg_data,
  input  logic          eoi,
  input  logic          eoi_sel,
  input  logic          inta,
  output logic          intr_out,
  output logic [VW-1:0] vec_out,
  output logic          vec_valid
);
  import pic_pkg::*;
  localparam int           LW       = $clog2(N);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC_LINE;

  logic          m_valid, s_valid, casc_ack;
  logic [LW-1:0] m_line, s_line;
  logic [VW-1:0] m_base, s_base, vec_next;
  logic [N-1:0]  m_level, m_pulse;
  logic          sel_m, sel_s, eoi_m, eoi_s;

  assign sel_m = (ctl_sel_e'(reg_sel) == SEL_MASTER);
  assign sel_s = (ctl_sel_e'(reg_sel) == SEL_SLAVE);
  assign eoi_m = eoi && (ctl_sel_e'(eoi_sel) == SEL_MASTER);
  assign eoi_s = eoi && (ctl_sel_e'(eoi_sel) == SEL_SLAVE);

  assign casc_ack = inta && m_valid && (m_line == LW'(CASC_LINE));
  // cascade line is fed only by the slave, as a pulse
  assign m_level  = master_irq & ~CASC_BIT;
  assign m_pulse  = (s_valid && !casc_ack) ? CASC_BIT : '0;

  pic_core #(.N(N), .VW(VW), .TRIG_MASK(M_TRIG_MASK), .LW(LW)) u_master (
    .clk(clk), .rst(rst), .req_level(m_level), .req_pulse(m_pulse),
    .mask_we(mask_we && sel_m), .trig_we(trig_we && sel_m), .base_we(base_we && sel_m),
    .wdata(reg_data), .eoi(eoi_m), .ack(inta),
    .pend_valid(m_valid), .pend_line(m_line), .base_q(m_base));

  pic_core #(.N(N), .VW(VW), .TRIG_MASK(S_TRIG_MASK), .LW(LW)) u_slave (
    .clk(clk), .rst(rst), .req_level(slave_irq), .req_pulse('0),
    .mask_we(mask_we && sel_s), .trig_we(trig_we && sel_s), .base_we(base_we && sel_s),
    .wdata(reg_data), .eoi(eoi_s), .ack(casc_ack),
    .pend_valid(s_valid), .pend_line(s_line), .base_q(s_base));

  assign intr_out = m_valid;

  always_comb begin
    if (!m_valid)      vec_next = vec_of(m_base, 3'(SPUR_LINE));
    else if (casc_ack) vec_next = s_valid ? vec_of(s_base, 3'(s_line))
                                          : vec_of(s_base, 3'(SPUR_LINE));
    else               vec_next = vec_of(m_base, 3'(m_line));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= inta;
      if (inta) vec_out <= vec_next;
    end
  end
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
  parameter int N = 8,
  parameter int VW = 8,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          inta,
  input logic          intr_out,
  input logic          vec_valid,
  input logic [VW-1:0] vec_out,
  input logic          m_valid,
  input logic [LW-1:0] m_line,
  input logic          s_valid,
  input logic [LW-1:0] s_line,
  input logic [VW-1:0] m_base,
  input logic [VW-1:0] s_base
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !vec_valid && !intr_out); // R1
  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) inta |=> vec_valid); // R6
  AST_VALID_ONLY_ACK: assert property (@(posedge clk) disable iff (rst) !inta |=> !vec_valid); // R6
  AST_DIRECT_VEC: assert property (@(posedge clk) disable iff (rst)
    inta && m_valid && m_line != LW'(2) |=> vec_out == $past(m_base) + VW'($past(m_line))); // R6
  AST_CASC_VEC: assert property (@(posedge clk) disable iff (rst)
    inta && m_valid && m_line == LW'(2) && s_valid |=> vec_out == $past(s_base) + VW'($past(s_line))); // R7
  AST_SPUR_MASTER: assert property (@(posedge clk) disable iff (rst)
    inta && !m_valid |=> vec_out == $past(m_base) + VW'(7)); // R8
  AST_SPUR_SLAVE: assert property (@(posedge clk) disable iff (rst)
    inta && m_valid && m_line == LW'(2) && !s_valid |=> vec_out == $past(s_base) + VW'(7)); // R9
endmodule

bind pic_cascade_top pic_cascade_chk #(.N(N), .VW(VW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .inta(inta), .intr_out(intr_out), .vec_valid(vec_valid),
  .vec_out(vec_out), .m_valid(m_valid), .m_line(m_line), .s_valid(s_valid),
  .s_line(s_line), .m_base(m_base), .s_base(s_base));

// File: tb/pic_cascade_top_test.sv
module pic_cascade_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] master_irq = '0, slave_irq = '0, reg_data = '0;
  logic       mask_we = 0, trig_we = 0, base_we = 0, reg_sel = 0;
  logic       eoi = 0, eoi_sel = 0, inta = 0;
  logic       intr_out, vec_valid;
  logic [7:0] vec_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pic_cascade_top uut (
    .clk(clk), .rst(rst), .master_irq(master_irq), .slave_irq(slave_irq),
    .mask_we(mask_we), .trig_we(trig_we), .base_we(base_we), .reg_sel(reg_sel),
    .reg_data(reg_data), .eoi(eoi), .eoi_sel(eoi_sel), .inta(inta),
    .intr_out(intr_out), .vec_out(vec_out), .vec_valid(vec_valid));

  // behavioural reference: index 0 master, 1 slave
  logic [7:0] irr[2], isr[2], imr[2], trg[2], lst[2], bas[2];
  logic [7:0] e_vec;
  logic       e_vv;

  function automatic int pend(int c);
    int r = 8, s = 8;
    for (int i = 7; i >= 0; i--) begin
      if (irr[c][i] && !imr[c][i]) r = i;
      if (isr[c][i]) s = i;
    end
    return (r < s) ? r : -1;
  endfunction

  task automatic step(int c, logic [7:0] lvl, logic [7:0] pls, bit ack, int line);
    logic [7:0] ah = '0, eh = '0, ni;
    int s = 8;
    if (ack) ah[line] = 1'b1;
    for (int i = 7; i >= 0; i--) if (isr[c][i]) s = i;
    if (eoi && int'(eoi_sel) == c && s < 8) eh[s] = 1'b1;
    for (int i = 0; i < 8; i++)
      if (trg[c][i]) ni[i] = lvl[i] | pls[i];
      else ni[i] = (irr[c][i] & ~ah[i]) | (lvl[i] & ~lst[c][i]) | pls[i];
    irr[c] = ni;
    isr[c] = (isr[c] | ah) & ~eh;
    lst[c] = lvl;
    if (int'(reg_sel) == c) begin
      if (mask_we) imr[c] = reg_data;
      if (trig_we) trg[c] = reg_data & ((c == 0) ? 8'hF8 : 8'hDE);
      if (base_we) bas[c] = reg_data & 8'hF8;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        irr[c] = 0; isr[c] = 0; imr[c] = 0; trg[c] = 0; lst[c] = 0; bas[c] = 0;
      end
      e_vec = 0; e_vv = 0;
    end else begin
      int mp, sp;
      bit casc;
      mp = pend(0);
      sp = pend(1);
      casc = inta && (mp == 2);
      e_vv = inta;
      if (inta) begin
        if (mp < 0) e_vec = bas[0] + 8'd7;
        else if (mp == 2) e_vec = (sp < 0) ? bas[1] + 8'd7 : bas[1] + 8'(sp);
        else e_vec = bas[0] + 8'(mp);
      end
      step(0, master_irq & 8'hFB, (sp >= 0 && !casc) ? 8'h04 : 8'h00, inta && mp >= 0, mp);
      step(1, slave_irq, 8'h00, casc && sp >= 0, sp);
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model comparison on every clock (R2 R3 R6 covered continuously)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 model intr_out", int'(intr_out), int'(pend(0) >= 0));
      check("R6 model vec_valid", int'(vec_valid), int'(e_vv));
      if (e_vv) check("R7 model vec_out", int'(vec_out), int'(e_vec));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int kind, bit sel, logic [7:0] d);
    reg_sel = sel; reg_data = d;
    mask_we = (kind == 0); trig_we = (kind == 1); base_we = (kind == 2);
    @(negedge clk);
    mask_we = 0; trig_we = 0; base_we = 0;
  endtask

  task automatic end_irq(bit sel);
    eoi = 1; eoi_sel = sel;
    @(negedge clk);
    eoi = 0;
  endtask

  task automatic ack(string tag, logic [7:0] exp);
    inta = 1;
    @(negedge clk);
    inta = 0;
    check({tag, " vec_valid"}, int'(vec_valid), 1);
    check({tag, " vec_out"}, int'(vec_out), int'(exp));
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    check("R1 intr_out", int'(intr_out), 0);
    check("R1 vec_valid", int'(vec_valid), 0);
    check("R1 vec_out", int'(vec_out), 0);

    wr(2, 0, 8'h0B);
    wr(2, 1, 8'h70);

    master_irq[2] = 1; tick(2);
    check("R5 master_irq[2] ignored", int'(intr_out), 0);
    master_irq[2] = 0;

    master_irq[4] = 1; tick(1);
    check("R2 intr after edge", int'(intr_out), 1);
    ack("R6 line4", 8'h0C);
    check("R2 intr after ack", int'(intr_out), 0);
    tick(1);
    check("R6 valid one cycle", int'(vec_valid), 0);

    master_irq[6] = 1; tick(1);
    check("R3 lower blocked", int'(intr_out), 0);
    master_irq[1] = 1; tick(1);
    check("R3 higher preempts", int'(intr_out), 1);
    ack("R3 line1", 8'h09);
    end_irq(0);
    check("R11 only line1 retired", int'(intr_out), 0);
    end_irq(0);
    check("R11 line4 retired", int'(intr_out), 1);
    ack("R3 line6", 8'h0E);
    end_irq(0);

    wr(0, 0, 8'h08);
    master_irq[3] = 1; tick(1);
    check("R4 masked", int'(intr_out), 0);
    wr(0, 0, 8'h00);
    check("R4 unmasked", int'(intr_out), 1);
    ack("R4 line3", 8'h0B);
    end_irq(0);

    slave_irq[5] = 1; tick(1);
    check("R5 one clock", int'(intr_out), 0);
    tick(1);
    check("R5 two clocks", int'(intr_out), 1);
    ack("R7 slave line5", 8'h75);
    check("R7 master line2 taken", int'(intr_out), 0);
    end_irq(1); end_irq(0); tick(1);

    ack("R8 spurious master", 8'h0F);

    slave_irq[3] = 1; tick(2);
    check("R5 slave line3 intr", int'(intr_out), 1);
    wr(0, 1, 8'h08);
    ack("R9 spurious slave", 8'h77);
    end_irq(0);
    wr(0, 1, 8'h00);
    check("R4 slave unmask lag", int'(intr_out), 0);
    tick(1);
    check("R4 slave unmask", int'(intr_out), 1);
    ack("R4 slave line3", 8'h73);
    end_irq(1); end_irq(0);

    master_irq = '0; slave_irq = '0; tick(1);

    wr(1, 1, 8'hFF);
    slave_irq[1] = 1; tick(2);
    ack("R10 slave level", 8'h71);
    end_irq(1); end_irq(0);
    check("R10 level persists", int'(intr_out), 1);
    slave_irq[1] = 0; tick(1);
    ack("R10 level dropped", 8'h77);
    end_irq(0); tick(1);
    check("R10 idle", int'(intr_out), 0);

    wr(1, 0, 8'hFF);
    master_irq[0] = 1; tick(1);
    ack("R10 line0", 8'h08);
    end_irq(0); tick(1);
    check("R10 line0 forced edge", int'(intr_out), 0);
    master_irq[6] = 1; tick(1);
    ack("R10 line6 level", 8'h0E);
    end_irq(0);
    check("R10 master level persists", int'(intr_out), 1);
    master_irq[6] = 0; tick(1);
    check("R10 master level drop", int'(intr_out), 0);

    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule